// File: doc/BRIEF.md
# Dual-Bank Interrupt Flag Controller

This block collects single-cycle event pulses from up to 32 internal sources and latches them into two independent flag banks. Each bank has its own enable mask, so one source can alert either host line, both, or neither. A shared polarity register picks, per line, whether an alert shows as a rise or a fall. A shared write-one-to-clear register releases flags in both banks at once.

Two register write ports reach the block. One is the host port behind the serial interface; the other is the internal sequencer port. Four custom software interrupt sources, at bit positions 12 down to 9, can be raised only by a sequencer write to the software-event address. Host writes to that address are dropped. A combinational readback port returns the masks, the polarity and the flags.

Address map (3-bit address): 0 = bank 0 enable mask, 1 = bank 1 enable mask, 2 = polarity (bit b drives line b), 3 = clear (write-only), 4 = bank 0 flags (read-only), 5 = bank 1 flags (read-only), 6 = software event (write-only, sequencer only).

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: After reset, every mask, flag and polarity register reads zero and both `irqOut` bits are 0.
- R2: An event pulse on `evtIn[i]` sets flag bit i of bank b on the next clock edge only if bit i is set in bank b's enable mask (address b). Banks are independent.
- R3: A set flag stays set after its event pulse ends, until it is cleared.
- R4: A write to address 3 from either port clears, in both banks, every flag bit written as 1. Bits written as 0 are left alone.
- R5: If a set event and a clear hit the same flag bit in the same cycle, the flag ends up set.
- R6: With polarity bit b at 0, `irqOut[b]` is 1 in the cycle after any bank-b flag becomes set, and returns to 0 once all bank-b flags are clear.
- R7: With polarity bit b at 1, `irqOut[b]` rests at 1 and is 0 while any bank-b flag is set.
- R8: A sequencer write to address 6 raises custom sources 9..12 from data bits 12..9. Pulses on `evtIn[12:9]` are ignored.
- R9: A host write to address 6 has no effect on any flag.
- R10: Only bit positions in mask 0xAF83BFFF exist. Every other position reads 0 in the masks and flags and can never be set.
- R11: If both ports write the same configuration register in one cycle, the sequencer value is kept.
- R12: The readback port returns the map above. Addresses 3, 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 32 | Single-cycle event pulses, one per source |
| hostWe | input | 1 | Host port write enable |
| hostAddr | input | 3 | Host port address |
| hostData | input | 32 | Host port write data |
| seqWe | input | 1 | Sequencer port write enable |
| seqAddr | input | 3 | Sequencer port address |
| seqData | input | 32 | Sequencer port write data |
| rdAddr | input | 3 | Readback address |
| rdData | output | 32 | Readback data (combinational) |
| irqOut | output | 2 | Interrupt line per bank |

## Verification
Events are pulsed as a single source, as several sources split across the two banks, and as all 32 lines at once. The single and split patterns separate per-bank masking from a shared mask. The all-ones pattern shows which positions exist and that external pulses cannot reach the custom bits. Clears are issued alone, from each port, and in the same cycle as a matching event; this separates set-wins behaviour from clear-wins. Polarity is toggled on one line only, so a swapped or shared polarity bit shows up. The software-event address is written from each port in turn, and the enable mask is written from both ports in one cycle, which exposes port-gating and write-priority faults.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_BANKS = 2;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 3;
  localparam int CUST_LSB  = 9;
  localparam int CUST_N    = 4;
  localparam logic [DATA_W-1:0] VALID_MASK = 32'hAF83_BFFF;
  localparam logic [DATA_W-1:0] CUST_MASK  = DATA_W'(((1 << CUST_N) - 1) << CUST_LSB);

  localparam logic [ADDR_W-1:0] ADR_SEL0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_POL  = ADDR_W'(NUM_BANKS);
  localparam logic [ADDR_W-1:0] ADR_CLR  = ADDR_W'(NUM_BANKS + 1);
  localparam logic [ADDR_W-1:0] ADR_FLG0 = ADDR_W'(NUM_BANKS + 2);
  localparam logic [ADDR_W-1:0] ADR_SWI  = ADDR_W'(2 * NUM_BANKS + 2);

  typedef struct packed {
    logic [NUM_BANKS-1:0]             selWe;
    logic [NUM_BANKS-1:0][DATA_W-1:0] selData;
    logic                             polWe;
    logic [NUM_BANKS-1:0]             polData;
    logic [DATA_W-1:0]                clrMask;
    logic [CUST_N-1:0]                swBits;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_write_ctrl.sv
module irq_write_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              seqWe,
  input  logic [ADDR_W-1:0] seqAddr,
  input  logic [DATA_W-1:0] seqData,
  output ctrl_strobe_t      strb
);
  // Host decoded first; sequencer decoded second so it overrides on collision.
  always_comb begin
    strb = '0;
    if (hostWe) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (hostAddr == ADR_SEL0 + ADDR_W'(b)) begin
          strb.selWe[b]   = 1'b1;
          strb.selData[b] = hostData;
        end
      end
      if (hostAddr == ADR_POL) begin
        strb.polWe   = 1'b1;
        strb.polData = hostData[NUM_BANKS-1:0];
      end
      if (hostAddr == ADR_CLR) strb.clrMask = strb.clrMask | hostData;
      // host writes to ADR_SWI are intentionally dropped
    end
    if (seqWe) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (seqAddr == ADR_SEL0 + ADDR_W'(b)) begin
          strb.selWe[b]   = 1'b1;
          strb.selData[b] = seqData;
        end
      end
      if (seqAddr == ADR_POL) begin
        strb.polWe   = 1'b1;
        strb.polData = seqData[NUM_BANKS-1:0];
      end
      if (seqAddr == ADR_CLR) strb.clrMask = strb.clrMask | seqData;
      if (seqAddr == ADR_SWI) strb.swBits = seqData[CUST_LSB +: CUST_N];
    end
  end
endmodule

// File: rtl/irq_flag_datapath.sv
module irq_flag_datapath
  import irq_ctrl_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [DATA_W-1:0]                evtIn,
  input  ctrl_strobe_t                     strb,
  input  logic [ADDR_W-1:0]                rdAddr,
  output logic [DATA_W-1:0]                rdData,
  output logic [NUM_BANKS-1:0]             irqOut,
  output logic [DATA_W-1:0]                srcVec,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] selVec,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] flagVec,
  output logic [NUM_BANKS-1:0]             polVec
);
  // External pulses cannot reach custom positions; only the sequencer strobe can.
  assign srcVec = ((evtIn & ~CUST_MASK) |
                   (DATA_W'(strb.swBits) << CUST_LSB)) & VALID_MASK;

  always_ff @(posedge clk) begin
    if (!rstN)           polVec <= '0;
    else if (strb.polWe) polVec <= strb.polData;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        selVec[b]  <= '0;
        flagVec[b] <= '0;
      end else begin
        if (strb.selWe[b]) selVec[b] <= strb.selData[b] & VALID_MASK;
        // set term ORed after clear term: set wins on collision
        flagVec[b] <= (flagVec[b] & ~strb.clrMask) | (srcVec & selVec[b]);
      end
    end
    assign irqOut[b] = (|flagVec[b]) ^ polVec[b];
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rdAddr == ADR_SEL0 + ADDR_W'(b)) rdData = selVec[b];
      if (rdAddr == ADR_FLG0 + ADDR_W'(b)) rdData = flagVec[b];
    end
    if (rdAddr == ADR_POL) rdData = DATA_W'(polVec);
  end
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    evtIn,
  input  logic                 hostWe,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostData,
  input  logic                 seqWe,
  input  logic [ADDR_W-1:0]    seqAddr,
  input  logic [DATA_W-1:0]    seqData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_BANKS-1:0] irqOut
);
  ctrl_strobe_t                     strb;
  logic [DATA_W-1:0]                srcVec;
  logic [NUM_BANKS-1:0][DATA_W-1:0] selVec;
  logic [NUM_BANKS-1:0][DATA_W-1:0] flagVec;
  logic [NUM_BANKS-1:0]             polVec;

  irq_write_ctrl u_ctrl (
    .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .seqWe(seqWe), .seqAddr(seqAddr), .seqData(seqData),
    .strb(strb)
  );

  irq_flag_datapath u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut),
    .srcVec(srcVec), .selVec(selVec), .flagVec(flagVec), .polVec(polVec)
  );
endmodule

// File: rtl/dual_bank_irq_chk.sv
module dual_bank_irq_chk
  import irq_ctrl_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic                             hostWe,
  input logic [ADDR_W-1:0]                hostAddr,
  input logic                             seqWe,
  input logic [CUST_N-1:0]                swBits,
  input logic [DATA_W-1:0]                clrMask,
  input logic [DATA_W-1:0]                srcVec,
  input logic [NUM_BANKS-1:0][DATA_W-1:0] selVec,
  input logic [NUM_BANKS-1:0][DATA_W-1:0] flagVec,
  input logic [NUM_BANKS-1:0]             polVec,
  input logic [NUM_BANKS-1:0]             irqOut
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R3: an uncleared flag never drops
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> ((($past(flagVec[b]) & ~$past(clrMask)) & ~flagVec[b]) == '0));
    // R5: enabled event always lands, even under a clear
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> ((($past(srcVec) & $past(selVec[b])) & ~flagVec[b]) == '0));
    // R10: nonexistent positions never hold a one
    assert_no_phantom_R10: assert property (@(posedge clk) disable iff (!rstN)
      ((flagVec[b] | selVec[b]) & ~VALID_MASK) == '0);
    // R6 / R7: line sits at its idle level whenever the bank is empty
    assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rstN)
      (flagVec[b] == '0) |-> (irqOut[b] == polVec[b]));
  end
  // R9: a host-only write to the software event address raises nothing
  assert_host_swi_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostAddr == ADR_SWI && !seqWe) |-> (swBits == '0));
endmodule

bind dual_bank_irq_ctrl dual_bank_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .seqWe(seqWe),
  .swBits(strb.swBits), .clrMask(strb.clrMask), .srcVec(srcVec),
  .selVec(selVec), .flagVec(flagVec), .polVec(polVec), .irqOut(irqOut)
);

// File: tb/dual_bank_irq_ctrl_tb.sv
module dual_bank_irq_ctrl_tb;
  import irq_ctrl_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [31:0]       evtIn = '0;
  logic              hostWe = 1'b0;
  logic [2:0]        hostAddr = '0;
  logic [31:0]       hostData = '0;
  logic              seqWe = 1'b0;
  logic [2:0]        seqAddr = '0;
  logic [31:0]       seqData = '0;
  logic [2:0]        rdAddr = '0;
  logic [31:0]       rdData;
  logic [1:0]        irqOut;
  int                nChecks = 0;
  int                nFails = 0;
  bit                done = 1'b0;

  always #2.5 clk = ~clk;

  dual_bank_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .seqWe(seqWe), .seqAddr(seqAddr), .seqData(seqData),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic hostWr(logic [2:0] a, logic [31:0] d);
    hostWe = 1'b1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic seqWr(logic [2:0] a, logic [31:0] d);
    seqWe = 1'b1; seqAddr = a; seqData = d;
    @(negedge clk);
    seqWe = 1'b0;
  endtask

  task automatic pulse(logic [31:0] v);
    evtIn = v;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic clearAll();
    seqWr(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1", d, 32'h0);
    end
    check("R1", 32'(irqOut), 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    hostWr(3'd0, 32'h0080_0001);
    hostWr(3'd1, 32'h0000_0002);
    evtIn = 32'h0000_0007;
    @(negedge clk);
    check("R6", 32'(irqOut), 32'h3);
    evtIn = '0;
    rd(3'd4, d); check("R2", d, 32'h0000_0001);
    rd(3'd5, d); check("R2", d, 32'h0000_0002);
    repeat (3) @(negedge clk);
    rd(3'd4, d); check("R3", d, 32'h0000_0001);
    check("R3", 32'(irqOut), 32'h3);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    hostWr(3'd3, 32'h0000_0001);
    rd(3'd4, d); check("R4", d, 32'h0);
    rd(3'd5, d); check("R4", d, 32'h0000_0002);
    check("R6", 32'(irqOut), 32'h2);
    seqWr(3'd3, 32'h0000_0002);
    rd(3'd5, d); check("R4", d, 32'h0);
    check("R6", 32'(irqOut), 32'h0);
  endtask

  task automatic t_setWins();
    logic [31:0] d;
    evtIn = 32'h0000_0001;
    seqWe = 1'b1; seqAddr = 3'd3; seqData = 32'h0000_0001;
    @(negedge clk);
    evtIn = '0; seqWe = 1'b0;
    rd(3'd4, d); check("R5", d, 32'h0000_0001);
    clearAll();
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    hostWr(3'd2, 32'h0000_0001);
    rd(3'd2, d); check("R12", d, 32'h1);
    check("R7", 32'(irqOut), 32'h1);
    pulse(32'h0000_0001);
    check("R7", 32'(irqOut), 32'h0);
    clearAll();
    check("R7", 32'(irqOut), 32'h1);
    hostWr(3'd2, 32'h0);
  endtask

  task automatic t_custom();
    logic [31:0] d;
    hostWr(3'd0, 32'h0000_1E00);
    pulse(32'h0000_1E00);
    rd(3'd4, d); check("R8", d, 32'h0);
    hostWr(3'd6, 32'h0000_1E00);
    rd(3'd4, d); check("R9", d, 32'h0);
    check("R9", 32'(irqOut), 32'h0);
    seqWr(3'd6, 32'h0000_0400);
    rd(3'd4, d); check("R8", d, 32'h0000_0400);
    rd(3'd6, d); check("R12", d, 32'h0);
    clearAll();
  endtask

  task automatic t_unassigned();
    logic [31:0] d;
    hostWr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R10", d, 32'hAF83_BFFF);
    pulse(32'hFFFF_FFFF);
    rd(3'd4, d); check("R10", d, 32'hAF83_A1FF);
    clearAll();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    hostWe = 1'b1; hostAddr = 3'd1; hostData = 32'h0000_0001;
    seqWe  = 1'b1; seqAddr  = 3'd1; seqData  = 32'h0000_0002;
    @(negedge clk);
    hostWe = 1'b0; seqWe = 1'b0;
    rd(3'd1, d); check("R11", d, 32'h0000_0002);
    rd(3'd3, d); check("R12", d, 32'h0);
    rd(3'd7, d); check("R12", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_clear();
    t_setWins();
    t_polarity();
    t_custom();
    t_unassigned();
    t_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule